// File: doc/BRIEF.md
# Match Report Buffer

An automaton engine raises a vector of report bits on every input symbol it consumes. This block sits after the engine and keeps those reports instead of passing them on one by one. Every accepted input whose report vector has at least one bit set becomes a stored event. The event holds the vector together with the position of that input inside the current window. Inputs whose vector is all zero leave nothing behind.

Inputs are counted in windows of a fixed length. When the last input of a window is accepted and at least one event is stored, the block stops taking input and sends the stored events to the host. Each event is cut into beats on an output bus narrower than the event, and the events leave in the order they arrived. When a window closes with nothing stored, the engine continues without losing a cycle.

The store has a fixed depth. Events that arrive after it is full are dropped, and a flag reports the loss until that window's flush is finished. The vector width, window length, output width and store depth are all parameters.

Top module: `match_report_buffer`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and overflow is 0.
- R2: When the last input of a window is accepted and no event is stored for that window, in_ready stays 1 and out_valid stays 0.
- R3: An accepted input with a nonzero in_report stores one event while fewer than DEPTH events are held. An accepted input with an all-zero in_report stores nothing.
- R4: The offset of an event is the number of inputs accepted earlier in the same window. It runs from 0 to WIN_LEN-1 and returns to 0 after the last input of a window.
- R5: In the cycle after the last input of a window is accepted with at least one event stored, out_valid becomes 1 and in_ready becomes 0. in_ready stays 0 for the whole flush.
- R6: Each event is sent as the word {offset, vector}, with the vector in bits VEC_W-1:0 and the offset in the next OFF_W bits, zero-padded above. The word goes out in ceil((VEC_W+OFF_W)/OUT_W) beats, lowest OUT_W bits first. out_last is 1 exactly on the final beat of each event.
- R7: Events leave in the order in which their inputs were accepted.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values into the next cycle.
- R9: An event that arrives while DEPTH events are stored is dropped, and overflow is 1 from the next cycle on. overflow returns to 0 in the cycle after the final beat of that flush is accepted.
- R10: in_ready returns to 1 in the cycle after the final beat of the last stored event is accepted.
- R11: A cycle with in_valid at 0 neither stores an event nor advances the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An input symbol's report vector is present |
| in_ready | output | 1 | The block accepts an input this cycle |
| in_report | input | VEC_W | Report bits for the current input |
| out_valid | output | 1 | An output beat is present |
| out_ready | input | 1 | The host takes the beat this cycle |
| out_data | output | OUT_W | Current slice of the event word |
| out_last | output | 1 | Final beat of the current event |
| overflow | output | 1 | Events were dropped in the current window |

## Verification
The bench builds the block with VEC_W=6, OUT_W=4, WIN_LEN=5 and DEPTH=3. This gives a 3-bit offset, a 9-bit event word split into three beats (the last one mostly padding), and a store small enough to overflow within a single window. Every one of the 64 report vectors passes through the block as an accepted input, so both the all-zero case and every nonzero bit pattern are covered. Further runs add gaps in in_valid, random host backpressure and sparse reports, which drive windows with zero, one, a few and too many events. A cycle-by-cycle arithmetic model in the bench predicts every port value.

// File: rtl/mrb_pkg.sv
package mrb_pkg;

  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_FLUSH   = 1'b1
  } mrb_state_e;

  function automatic int unsigned ceil_div(int unsigned a, int unsigned b);
    return (a + b - 1) / b;
  endfunction

  // index width that stays at least one bit
  function automatic int unsigned idx_width(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/mrb_offset_ctr.sv
module mrb_offset_ctr #(
  parameter int unsigned WIN_LEN = 1000,
  parameter int unsigned OFF_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [OFF_W-1:0] offset,
  output logic             wrap
);

  logic [OFF_W-1:0] offset_d;

  assign wrap = step && (offset == OFF_W'(WIN_LEN - 1));

  always_comb begin
    offset_d = offset;
    if (step) offset_d = wrap ? '0 : offset + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) offset <= '0;
    else        offset <= offset_d;
  end

  // R4: offset never leaves the window
  a_r4_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
    offset <= OFF_W'(WIN_LEN - 1));

  // R11: no step, no movement
  a_r11_hold_offset: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(offset));

endmodule

// File: rtl/mrb_event_store.sv
module mrb_event_store #(
  parameter int unsigned EV_W  = 16,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [EV_W-1:0]  push_data,
  input  logic             clear,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [EV_W-1:0]  rd_data,
  output logic [CNT_W-1:0] count,
  output logic             overflow
);

  logic [EV_W-1:0]  mem [DEPTH];
  logic [CNT_W-1:0] count_d;
  logic             overflow_d;
  logic             full;
  logic             wr_en;

  assign full    = (count == CNT_W'(DEPTH));
  assign wr_en   = push && !full;
  assign rd_data = mem[rd_idx];

  always_comb begin
    count_d    = count;
    overflow_d = overflow;
    if (clear) begin
      count_d    = '0;
      overflow_d = 1'b0;
    end else if (push) begin
      if (full) overflow_d = 1'b1;
      else      count_d    = count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      count    <= count_d;
      overflow <= overflow_d;
    end
  end

  // storage has no reset; a slot is read only after it is written
  always_ff @(posedge clk) begin
    if (wr_en) mem[count[IDX_W-1:0]] <= push_data;
  end

  // R3: never more events than slots
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R9: the flag only rises after a push met a full store
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($past(count) == CNT_W'(DEPTH)) && $past(push));

endmodule

// File: rtl/mrb_flush_ser.sv
module mrb_flush_ser
  import mrb_pkg::*;
#(
  parameter int unsigned EV_W  = 16,
  parameter int unsigned OUT_W = 4,
  parameter int unsigned BEATS = 4,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned BT_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic [EV_W-1:0]  rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             out_last,
  output logic             busy,
  output logic             done
);

  localparam int unsigned PAD_W = BEATS * OUT_W;

  mrb_state_e       st, st_d;
  logic [IDX_W-1:0] rd_d;
  logic [BT_W-1:0]  beat, beat_d;
  logic [PAD_W-1:0] padded;
  logic [OUT_W-1:0] slices [BEATS];
  logic             fire;
  logic             last_evt;

  assign padded = PAD_W'(rd_data);

  for (genvar g = 0; g < BEATS; g++) begin : g_slice
    assign slices[g] = padded[g*OUT_W +: OUT_W];
  end

  assign busy      = (st == ST_FLUSH);
  assign out_valid = busy;
  assign out_data  = slices[beat];
  assign out_last  = busy && (beat == BT_W'(BEATS - 1));
  assign fire      = out_valid && out_ready;
  assign last_evt  = ((CNT_W'(rd_idx) + CNT_W'(1)) == count);
  assign done      = fire && out_last && last_evt;

  always_comb begin
    st_d   = st;
    rd_d   = rd_idx;
    beat_d = beat;
    unique case (st)
      ST_COLLECT: begin
        if (start) begin
          st_d   = ST_FLUSH;
          rd_d   = '0;
          beat_d = '0;
        end
      end
      ST_FLUSH: begin
        if (fire) begin
          if (out_last) begin
            beat_d = '0;
            if (last_evt) begin
              st_d = ST_COLLECT;
              rd_d = '0;
            end else begin
              rd_d = rd_idx + 1'b1;
            end
          end else begin
            beat_d = beat + 1'b1;
          end
        end
      end
      default: st_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_COLLECT;
      rd_idx <= '0;
      beat   <= '0;
    end else begin
      st     <= st_d;
      rd_idx <= rd_d;
      beat   <= beat_d;
    end
  end

  // R8: a stalled beat is held
  a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R10: flush ends right after the final beat is taken
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R5: a flush request begins a flush
  a_r5_flush_starts: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

endmodule

// File: rtl/match_report_buffer.sv
module match_report_buffer
  import mrb_pkg::*;
#(
  parameter int unsigned VEC_W   = 32,
  parameter int unsigned OUT_W   = 8,
  parameter int unsigned WIN_LEN = 1000,
  parameter int unsigned DEPTH   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_report,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             out_last,
  output logic             overflow
);

  localparam int unsigned OFF_W = idx_width(WIN_LEN);
  localparam int unsigned EV_W  = VEC_W + OFF_W;
  localparam int unsigned BEATS = ceil_div(EV_W, OUT_W);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = idx_width(DEPTH);
  localparam int unsigned BT_W  = idx_width(BEATS);

  logic             accept;
  logic             hit;
  logic             wrap;
  logic             have_evt;
  logic             start;
  logic             busy;
  logic             done;
  logic [OFF_W-1:0] offset;
  logic [CNT_W-1:0] count;
  logic [IDX_W-1:0] rd_idx;
  logic [EV_W-1:0]  rd_data;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign hit      = accept && (|in_report);
  assign have_evt = (count != '0) || hit;
  assign start    = wrap && have_evt;

  mrb_offset_ctr #(.WIN_LEN(WIN_LEN), .OFF_W(OFF_W)) u_offset (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (accept),
    .offset (offset),
    .wrap   (wrap)
  );

  mrb_event_store #(.EV_W(EV_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (hit),
    .push_data ({offset, in_report}),
    .clear     (done),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .count     (count),
    .overflow  (overflow)
  );

  mrb_flush_ser #(
    .EV_W(EV_W), .OUT_W(OUT_W), .BEATS(BEATS),
    .CNT_W(CNT_W), .IDX_W(IDX_W), .BT_W(BT_W)
  ) u_flush (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .count     (count),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .busy      (busy),
    .done      (done)
  );

  // R2: an empty window closes without a stall
  a_r2_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && !have_evt |=> in_ready && !out_valid);

  // R5: a window with events closes into a flush
  a_r5_stall_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && have_evt |=> !in_ready && out_valid);

endmodule

// File: tb/match_report_buffer_tb_top.sv
module match_report_buffer_tb_top;

  localparam int VEC_W = 6;
  localparam int OUT_W = 4;
  localparam int WIN   = 5;
  localparam int DEPTH = 3;
  localparam int OFF_W = 3;
  localparam int EV_W  = VEC_W + OFF_W;
  localparam int BEATS = (EV_W + OUT_W - 1) / OUT_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic [VEC_W-1:0] in_report;
  logic             out_valid;
  logic             out_ready;
  logic [OUT_W-1:0] out_data;
  logic             out_last;
  logic             overflow;

  always #2 clk = ~clk;

  match_report_buffer #(.VEC_W(VEC_W), .OUT_W(OUT_W), .WIN_LEN(WIN), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_report(in_report), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .overflow(overflow)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  bit m_fl = 0;
  bit m_ovf = 0;
  bit m_stalled = 0;
  bit m_justdone = 0;
  int m_pos = 0, m_cnt = 0, m_rd = 0, m_beat = 0;
  int m_q [DEPTH];
  int lfsr = 32'h1ace;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cycles);
    end
  endtask

  function automatic int rnd();
    lfsr = lfsr * 1103515245 + 12345;
    return (lfsr >>> 16) & 32'h7fff;
  endfunction

  // one clock: check outputs, drive, advance model; starts and ends at negedge
  task automatic step(bit iv, int rep, bit ordy);
    int ev;
    ev = m_fl ? m_q[m_rd] : 0;
    chk(m_justdone ? "R10 in_ready" : (m_fl ? "R5 in_ready" : "R2 in_ready"),
        int'(in_ready), int'(!m_fl));
    chk("R5 out_valid", int'(out_valid), int'(m_fl));
    chk("R9 overflow", int'(overflow), int'(m_ovf));
    if (m_fl) begin
      chk(m_stalled ? "R8 out_data" : "R3 R4 R6 R7 R11 out_data", int'(out_data),
          (ev >> (m_beat * OUT_W)) & ((1 << OUT_W) - 1));
      chk("R6 out_last", int'(out_last), int'(m_beat == BEATS - 1));
    end
    in_valid  = iv;
    in_report = VEC_W'(rep);
    out_ready = ordy;
    @(posedge clk);
    m_justdone = 0;
    m_stalled  = m_fl && !ordy;
    if (!m_fl) begin
      if (iv) begin
        if (rep != 0) begin
          if (m_cnt < DEPTH) begin
            m_q[m_cnt] = (m_pos << VEC_W) | rep;
            m_cnt++;
          end else m_ovf = 1;
        end
        if (m_pos == WIN - 1) begin
          m_pos = 0;
          if (m_cnt > 0) begin m_fl = 1; m_rd = 0; m_beat = 0; end
        end else m_pos++;
      end
    end else if (ordy) begin
      if (m_beat == BEATS - 1) begin
        m_beat = 0;
        if (m_rd == m_cnt - 1) begin
          m_fl = 0; m_cnt = 0; m_rd = 0; m_ovf = 0; m_justdone = 1;
        end else m_rd++;
      end else m_beat++;
    end
    @(negedge clk);
    cycles++;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; in_report = '0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 overflow", int'(overflow), 0);

    // R2: three empty windows, never stalled
    for (int i = 0; i < 3 * WIN; i++) step(1, 0, 1);

    // a single report at the last position of a window
    for (int i = 0; i < WIN - 1; i++) step(1, 0, 1);
    step(1, 6'h2a, 1);
    while (m_fl) step(1, 6'h3f, 1);

    // R3 R6: sweep every report vector, ready toggling
    for (int v = 0; v < 64; v++) begin
      step(1, v, v[0]);
      while (m_fl) step(1, 6'h01, (rnd() & 1) == 1);
    end

    // R9: overflow window, slow host
    for (int i = 0; i < WIN; i++) step(1, i + 1, 0);
    while (m_fl) step(0, 0, (rnd() % 3) == 0);

    // R11 R8: gaps in input, sparse reports, random backpressure
    for (int i = 0; i < 600; i++) begin
      int r;
      r = rnd();
      step((r & 3) != 0, ((r >> 2) % 5 == 0) ? ((r >> 5) & 63) : 0, (r >> 11) % 3 != 0);
    end
    while (m_fl) step(0, 0, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 1);
    summary();
  end

endmodule